// File: doc/BRIEF.md
# Pixel Arithmetic-Logic Unit with Carry-Select Groups

This block combines two unsigned intensity samples, A and B, into a result that is one bit wider than the inputs. A 6-bit operation code selects one of 48 functions. Codes 0 to 15 apply a bitwise logic function to each bit pair of A and B. Codes 16 to 31 form an arithmetic sum of two operand terms with no carry-in. Codes 32 to 47 compute the same sums as codes 16 to 31, but with a carry-in of one. The extra top bit holds the carry-out of the sum. Sums can therefore reach 511, and subtraction reports its sign through that top bit.

The block sits in a pixel stream between an input mapping stage and a result mapping stage. A sample is taken whenever the input strobe is high. One clock later the result appears on a registered output, together with a matching valid flag. When the strobe is low, the output register keeps its contents. Codes 48 to 63 are reserved: they return zero and raise an illegal-code flag.

Top module: `pxalu_top`

## Requirements
- R1: For codes 0 to 15, each result bit j below 8 is a logic function of A[j] and B[j], and result bit 8 is 0. The functions for codes 0 to 15, in code order, are: not A, nor, (not A) and B, constant 0, nand, not B, xor, A and (not B), not A, xnor, B, and, constant 1 (result 0x0FF), A or (not B), or, A.
- R2: For codes 16 to 31, the result is the 9-bit sum of two terms with carry-in 0. The sums for codes 16 to 31, in code order, are: A, A|B, A|~B, 0x0FF, A+(A&~B), (A|B)+(A&~B), A+~B, (A|~B)+0xFF, A+(A&B), A+B, (A|~B)+(A&B), (A&B)+0xFF, A+A, (A|B)+A, (A|~B)+A, A+0xFF.
- R3: For codes 32 to 47, the result equals the result of code (c-16) on the same operands plus one.
- R4: Code 22 returns 256+(A-B-1) and code 38 returns 256+(A-B). This holds when that difference is zero or more. When the difference is negative, both codes return 256 plus the negative difference, which lies in 0 to 255.
- R5: The "minus one" codes add 0xFF to their first term. Code 19 returns 0x0FF and code 35 returns 0x100. Code 31 returns A+255 and code 47 returns A+256.
- R6: Codes 48 to 63 give result 0 with the illegal flag set to 1. Every code from 0 to 47 gives an illegal flag of 0.
- R7: out_valid equals in_valid from the previous clock. The result and the illegal flag of an accepted sample appear exactly one clock after it is accepted.
- R8: While in_valid is low, result and illegal keep their previous values, whatever op, A and B are doing.
- R9: A synchronous active-high reset clears out_valid, result and illegal at the next clock edge. Reset takes priority over a valid input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for op, opa and opb |
| op | input | 6 | Operation code, 0 to 63 |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | DATA_W+1 | Registered result; top bit is the carry-out |
| illegal | output | 1 | Registered flag for a reserved code |

## Verification
Two events can fall in the same cycle: a reserved code can arrive while the strobe is low, and the output register must keep its contents at the same time. The bench provokes this by sending a reserved code with operands that change on every cycle while the strobe is low. It judges the cycle by checking that both the held result and the held illegal flag keep their earlier values. A second collision is reset with the strobe high, where reset must win. The reference model computes every code directly as signed integer arithmetic on the operands, and the bench compares its result with the design on every clock.

// File: rtl/pxalu_pkg.sv
package pxalu_pkg;

  typedef enum logic [1:0] {
    GRP_LOGIC = 2'd0,
    GRP_ADD   = 2'd1,
    GRP_ADDC  = 2'd2,
    GRP_RSVD  = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    X_A, X_AORB, X_AORNB, X_ZERO, X_AANDB
  } xsel_e;

  typedef enum logic [2:0] {
    Y_ZERO, Y_AANDNB, Y_NB, Y_ONES, Y_AANDB, Y_B, Y_A
  } ysel_e;

  // Truth table indexed by {a_bit, b_bit}
  function automatic logic [3:0] truth_of(input logic [3:0] sel);
    case (sel)
      4'd0:  truth_of = 4'b0011;
      4'd1:  truth_of = 4'b0001;
      4'd2:  truth_of = 4'b0010;
      4'd3:  truth_of = 4'b0000;
      4'd4:  truth_of = 4'b0111;
      4'd5:  truth_of = 4'b0101;
      4'd6:  truth_of = 4'b0110;
      4'd7:  truth_of = 4'b0100;
      4'd8:  truth_of = 4'b0011;
      4'd9:  truth_of = 4'b1001;
      4'd10: truth_of = 4'b1010;
      4'd11: truth_of = 4'b1000;
      4'd12: truth_of = 4'b1111;
      4'd13: truth_of = 4'b1101;
      4'd14: truth_of = 4'b1110;
      default: truth_of = 4'b1100;
    endcase
  endfunction

  function automatic xsel_e xsel_of(input logic [3:0] sel);
    case (sel)
      4'd1, 4'd5, 4'd13:  xsel_of = X_AORB;
      4'd2, 4'd7, 4'd10, 4'd14: xsel_of = X_AORNB;
      4'd3:               xsel_of = X_ZERO;
      4'd11:              xsel_of = X_AANDB;
      default:            xsel_of = X_A;
    endcase
  endfunction

  function automatic ysel_e ysel_of(input logic [3:0] sel);
    case (sel)
      4'd4, 4'd5:                 ysel_of = Y_AANDNB;
      4'd6:                       ysel_of = Y_NB;
      4'd3, 4'd7, 4'd11, 4'd15:   ysel_of = Y_ONES;
      4'd8, 4'd10:                ysel_of = Y_AANDB;
      4'd9:                       ysel_of = Y_B;
      4'd12, 4'd13, 4'd14:        ysel_of = Y_A;
      default:                    ysel_of = Y_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/pxalu_logic.sv
module pxalu_logic #(
  parameter int W = 8
) (
  input  logic [3:0]   sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import pxalu_pkg::*;

  logic [3:0] tt;
  assign tt = truth_of(sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = tt[{a[i], b[i]}];
  end

endmodule

// File: rtl/pxalu_arith.sv
module pxalu_arith #(
  parameter int W = 8
) (
  input  logic [3:0]   sel,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   y
);
  import pxalu_pkg::*;

  xsel_e xs;
  ysel_e ys;
  logic [W-1:0] x_term;
  logic [W-1:0] y_term;

  assign xs = xsel_of(sel);
  assign ys = ysel_of(sel);

  always_comb begin
    case (xs)
      X_AORB:  x_term = a | b;
      X_AORNB: x_term = a | ~b;
      X_ZERO:  x_term = '0;
      X_AANDB: x_term = a & b;
      default: x_term = a;
    endcase
  end

  always_comb begin
    case (ys)
      Y_AANDNB: y_term = a & ~b;
      Y_NB:     y_term = ~b;
      Y_ONES:   y_term = '1;
      Y_AANDB:  y_term = a & b;
      Y_B:      y_term = b;
      Y_A:      y_term = a;
      default:  y_term = '0;
    endcase
  end

  assign y = {1'b0, x_term} + {1'b0, y_term} + {{W{1'b0}}, cin};

endmodule

// File: rtl/pxalu_top.sv
module pxalu_top #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [5:0]        op,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              out_valid,
  output logic [DATA_W:0]   result,
  output logic              illegal
);
  import pxalu_pkg::*;

  localparam int RES_W = DATA_W + 1;

  grp_e             grp;
  logic [3:0]       sel;
  logic [DATA_W-1:0] logic_y;
  logic [RES_W-1:0] arith_y;
  logic [RES_W-1:0] nxt_res;

  assign grp = grp_e'(op[5:4]);
  assign sel = op[3:0];

  pxalu_logic #(.W(DATA_W)) u_logic (
    .sel (sel),
    .a   (opa),
    .b   (opb),
    .y   (logic_y)
  );

  pxalu_arith #(.W(DATA_W)) u_arith (
    .sel (sel),
    .cin (grp == GRP_ADDC),
    .a   (opa),
    .b   (opb),
    .y   (arith_y)
  );

  always_comb begin
    case (grp)
      GRP_LOGIC:          nxt_res = {1'b0, logic_y};
      GRP_ADD, GRP_ADDC:  nxt_res = arith_y;
      default:            nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= nxt_res;
        illegal <= (grp == GRP_RSVD);
      end
    end
  end

endmodule

// File: rtl/pxalu_chk.sv
module pxalu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [5:0]        op,
  input logic [DATA_W:0]   result,
  input logic              out_valid,
  input logic              illegal
);
  logic past_ok;
  logic rst_q;

  always_ff @(posedge clk) begin
    past_ok <= !rst;
    rst_q   <= rst;
  end

  // R9: reset clears outputs
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r9_reset_clear: assert (out_valid == 1'b0 && result == '0 && illegal == 1'b0);
    end
  end

  // R7
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (out_valid == $past(in_valid)));

  // R6
  a_r6_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (result == '0));

  // R6
  a_r6_flag_on_reserved: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid)) |-> (illegal == ($past(op[5:4]) == 2'b11)));

  // R1
  a_r1_logic_msb_clear: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid) && $past(op[5:4]) == 2'b00) |-> (result[DATA_W] == 1'b0));

  // R8
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(in_valid)) |-> ($stable(result) && $stable(illegal)));

endmodule

bind pxalu_top pxalu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op        (op),
  .result    (result),
  .out_valid (out_valid),
  .illegal   (illegal)
);

// File: tb/test_pxalu_top.sv
`timescale 1ns/1ps
module test_pxalu_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [5:0] op = '0;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic       out_valid;
  logic [8:0] result;
  logic       illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int exp_v = 0;
  int exp_r = 0;
  int exp_i = 0;

  always #2 clk = ~clk;

  pxalu_top #(.DATA_W(8)) i_pxalu_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .illegal(illegal)
  );

  function automatic int ref_res(int o, int a, int b);
    int na = 255 - a;
    int nb = 255 - b;
    int c;
    int k;
    if (o >= 48) return 0;
    if (o < 16) begin
      case (o)
        0: return na;            1: return 255 - (a | b);
        2: return na & b;        3: return 0;
        4: return 255 - (a & b); 5: return nb;
        6: return a ^ b;         7: return a & nb;
        8: return na;            9: return 255 - (a ^ b);
        10: return b;            11: return a & b;
        12: return 255;          13: return a | nb;
        14: return a | b;        default: return a;
      endcase
    end
    c = (o >= 32) ? 1 : 0;
    k = o % 16;
    case (k)
      0: return a + c;
      1: return (a | b) + c;
      2: return (a | nb) + c;
      3: return 256 - 1 + c;
      4: return a + (a & nb) + c;
      5: return (a | b) + (a & nb) + c;
      6: return 256 + (a - b - 1) + c;
      7: return 256 + ((a | nb) - 1) + c;
      8: return a + (a & b) + c;
      9: return a + b + c;
      10: return (a | nb) + (a & b) + c;
      11: return 256 + ((a & b) - 1) + c;
      12: return 2 * a + c;
      13: return (a | b) + a + c;
      14: return (a | nb) + a + c;
      default: return 256 + (a - 1) + c;
    endcase
  endfunction

  function automatic string tag_of(int o);
    if (o >= 48) return "R6";
    if (o < 16) return "R1";
    if (o == 22 || o == 38) return "R4";
    if ((o % 16) == 3 || (o % 16) == 15) return "R5";
    if (o >= 32) return "R3";
    return "R2";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (op=%0d a=%0d b=%0d)",
               tag, what, act, exp, op, opa, opb);
    end
  endtask

  task automatic cyc(bit r, bit v, int o, int a, int b);
    string t;
    @(negedge clk);
    rst = r; in_valid = v; op = 6'(o); opa = 8'(a); opb = 8'(b);
    @(posedge clk);
    #1;
    if (r) begin
      exp_v = 0; exp_r = 0; exp_i = 0; t = "R9";
    end else begin
      exp_v = v;
      if (v) begin
        exp_r = ref_res(o, a, b);
        exp_i = (o >= 48) ? 1 : 0;
        t = tag_of(o);
      end else begin
        t = "R8";
      end
    end
    check(r ? "R9" : "R7", "out_valid", int'(out_valid), exp_v);
    check(t, "result", int'(result), exp_r);
    check((r || !v) ? t : "R6", "illegal", int'(illegal), exp_i);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int corner_a[6] = '{0, 255, 255, 0, 128, 127};
    int corner_b[6] = '{0, 255, 0, 255, 127, 128};
    // R9 reset state
    repeat (3) cyc(1, 0, 0, 0, 0);
    // Sweep every code with corner and random operands (R1..R6)
    for (int o = 0; o < 64; o++) begin
      for (int k = 0; k < 6; k++) cyc(0, 1, o, corner_a[k], corner_b[k]);
      for (int k = 0; k < 20; k++) cyc(0, 1, o, $urandom_range(0, 255), $urandom_range(0, 255));
    end
    // R4 subtraction with equal operands and one-apart operands
    cyc(0, 1, 22, 77, 77);
    cyc(0, 1, 38, 77, 77);
    cyc(0, 1, 22, 78, 77);
    cyc(0, 1, 38, 76, 77);
    // R5 constant minus-one codes
    cyc(0, 1, 19, 10, 20);
    cyc(0, 1, 35, 10, 20);
    // R8: reserved code presented while idle, result must hold a legal value
    cyc(0, 1, 41, 200, 100);
    for (int k = 0; k < 8; k++) cyc(0, 0, 48 + k, $urandom_range(0, 255), $urandom_range(0, 255));
    // R8: hold an illegal flag while legal codes pass idle
    cyc(0, 1, 60, 5, 6);
    for (int k = 0; k < 5; k++) cyc(0, 0, k, 9, 9);
    // R7: valid toggling pattern
    for (int k = 0; k < 40; k++) cyc(0, k % 3 != 0, $urandom_range(0, 63),
                                     $urandom_range(0, 255), $urandom_range(0, 255));
    // R9: reset wins over a valid input
    cyc(0, 1, 44, 255, 0);
    cyc(1, 1, 44, 255, 255);
    cyc(0, 1, 12, 0, 0);
    // Random mix
    for (int k = 0; k < 300; k++) cyc(0, $urandom_range(0, 1), $urandom_range(0, 63),
                                      $urandom_range(0, 255), $urandom_range(0, 255));
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule